// File: doc/BRIEF.md
# Threshold-Driven FIFO Service Requester

This block sits between a disk-side byte stream and a host or DMA port. It keeps a small byte FIFO and decides when the host side must be asked for service. The transfer direction is chosen by one input. In disk-to-host (read) transfers, the disk side pushes bytes and the host pops them. In host-to-disk (write) transfers, the host pushes and the disk side pops.

The request is driven by a programmable threshold, but it is not a plain level comparison. In the read direction, the request rises once the FIFO has filled to a programmed mark, or when the final byte of a sector arrives. It then holds until the FIFO is drained. In the write direction, the request rises when the execution phase begins. It falls when the FIFO fills and comes back when occupancy drops to the threshold. A terminal count ends it. The request goes out either as an interrupt line with a matching polled status bit, or as a DMA request line. A result-ready flag tells the command logic that a write transfer has fully drained.

Top module: `fifo_svc_req`

## Requirements
- R1: The effective threshold is `thr_cfg + 1`, so it spans 1 to DEPTH bytes (4-bit field, 1..16 at defaults).
- R2: With `to_host`=1, the request is registered high on the clock edge at which occupancy becomes at least DEPTH minus threshold, and the FIFO is not empty.
- R3: With `to_host`=1, a `sector_end` pulse forces the request high at that edge, unless the FIFO ends the cycle empty.
- R4: With `to_host`=1, once raised, the request stays high until occupancy becomes 0. It falls on that same edge.
- R5: With `to_host`=0, an `exec_start` pulse raises the request on the next edge. It also starts the transfer and clears any previous completion.
- R6: With `to_host`=0, the request falls on the edge at which the FIFO becomes full (DEPTH bytes). It rises again on the edge at which occupancy becomes exactly the threshold.
- R7: A `term_count` pulse ends the transfer. With `to_host`=0, the request then stays low, and `result_ok` is high exactly while the FIFO is empty after a terminal count.
- R8: With `dma_mode`=0, `irq` and `rqm` both carry the request and `dma_req` is 0. With `dma_mode`=1, only `dma_req` carries it.
- R9: A push while full and a pop while empty leave the FIFO unchanged. Either one sets `err_flag`, which stays set until reset.
- R10: Bytes come out in push order on `rd_data`, and `level` reports occupancy after each edge.
- R11: After reset, the FIFO is empty and the request, `result_ok` and `err_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| to_host | input | 1 | 1 = disk-to-host transfer, 0 = host-to-disk |
| dma_mode | input | 1 | 1 = request on DMA line, 0 = interrupt/status bit |
| thr_cfg | input | 4 | Programmed threshold minus one |
| exec_start | input | 1 | Pulse on entry to the execution phase |
| sector_end | input | 1 | Pulse with the final byte of a full sector |
| term_count | input | 1 | Terminal count pulse |
| disk_wr | input | 1 | Disk-side push (read direction) |
| disk_wdata | input | 8 | Disk-side push byte |
| disk_rd | input | 1 | Disk-side pop (write direction) |
| host_wr | input | 1 | Host-side push (write direction) |
| host_wdata | input | 8 | Host-side push byte |
| host_rd | input | 1 | Host-side pop (read direction) |
| rd_data | output | 8 | FIFO head byte |
| level | output | 5 | FIFO occupancy |
| irq | output | 1 | Interrupt service request |
| rqm | output | 1 | Polled request status bit |
| dma_req | output | 1 | DMA service request |
| result_ok | output | 1 | Write transfer drained after terminal count |
| err_flag | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions assume that `to_host` holds steady across any cycle they inspect. They also treat a push or pop as coming from the strobe pair that the current direction selects. The stimulus follows this by changing the direction only while reset is asserted. It never pulses `exec_start` and `term_count` together, and it never starts execution with a full FIFO. The per-cycle model in the bench also drives over-full pushes, empty pops and mode switches in the middle of a transfer, so that both the error path and the output routing are exercised.

// File: rtl/svc_pkg.sv
package svc_pkg;
   typedef enum logic {
      XFER_TO_DISK = 1'b0,
      XFER_TO_HOST = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/svc_fifo.sv
module svc_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  count_nxt,
   output logic              bad_op
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              full, empty, push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign bad_op  = (push && full) || (pop && empty);
   assign rdata   = mem[rd_ptr];

   always_comb begin
      count_nxt = count;
      if (push_ok && !pop_ok) count_nxt = count + 1'b1;
      if (pop_ok && !push_ok) count_nxt = count - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         count <= count_nxt;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_ok && wr_ptr == PTR_W'(i)) mem[i] <= wdata;
      end
   end
endmodule

// File: rtl/svc_req_ctl.sv
module svc_req_ctl
   import svc_pkg::*;
#(
   parameter int DEPTH  = 16,
   localparam int THR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xfer_dir_e        dir,
   input  logic [THR_W-1:0] thr_cfg,
   input  logic             exec_start,
   input  logic             sector_end,
   input  logic             term_count,
   input  logic [CNT_W-1:0] level_nxt,
   output logic             req,
   output logic             result_ok
);
   logic [CNT_W-1:0] thr, fill_mark;
   logic             act, done, act_n, done_n, req_n, res_n;

   assign thr       = CNT_W'(thr_cfg) + 1'b1;
   assign fill_mark = CNT_W'(DEPTH) - thr;

   always_comb begin
      act_n = act;
      if (exec_start) act_n = 1'b1;
      if (term_count) act_n = 1'b0;
      done_n = done;
      if (term_count) done_n = 1'b1;
      if (exec_start) done_n = 1'b0;

      if (dir == XFER_TO_HOST) begin
         if (level_nxt == '0)                           req_n = 1'b0;
         else if (level_nxt >= fill_mark || sector_end) req_n = 1'b1;
         else                                           req_n = req;
      end else begin
         if (!act_n)                              req_n = 1'b0;
         else if (level_nxt == CNT_W'(DEPTH))     req_n = 1'b0;
         else if (exec_start)                     req_n = 1'b1;
         else if (level_nxt == thr)               req_n = 1'b1;
         else                                     req_n = req;
      end
      res_n = (dir == XFER_TO_DISK) && done_n && (level_nxt == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act       <= 1'b0;
         done      <= 1'b0;
         req       <= 1'b0;
         result_ok <= 1'b0;
      end else begin
         act       <= act_n;
         done      <= done_n;
         req       <= req_n;
         result_ok <= res_n;
      end
   end
endmodule

// File: rtl/fifo_svc_req.sv
module fifo_svc_req
   import svc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 16,
   parameter bit DUAL_OUT = 1'b1,
   localparam int THR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              to_host,
   input  logic              dma_mode,
   input  logic [THR_W-1:0]  thr_cfg,
   input  logic              exec_start,
   input  logic              sector_end,
   input  logic              term_count,
   input  logic              disk_wr,
   input  logic [DATA_W-1:0] disk_wdata,
   input  logic              disk_rd,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  level,
   output logic              irq,
   output logic              rqm,
   output logic              dma_req,
   output logic              result_ok,
   output logic              err_flag
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fifo_svc_req: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("fifo_svc_req: DATA_W must be positive");
   end

   xfer_dir_e        dir;
   logic             push, pop, bad_op, req;
   logic [DATA_W-1:0] push_data;
   logic [CNT_W-1:0] level_nxt;

   assign dir       = xfer_dir_e'(to_host);
   assign push      = (dir == XFER_TO_HOST) ? disk_wr    : host_wr;
   assign pop       = (dir == XFER_TO_HOST) ? host_rd    : disk_rd;
   assign push_data = (dir == XFER_TO_HOST) ? disk_wdata : host_wdata;

   svc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_data), .pop(pop),
      .rdata(rd_data), .count(level), .count_nxt(level_nxt), .bad_op(bad_op)
   );

   svc_req_ctl #(.DEPTH(DEPTH)) u_ctl (
      .clk(clk), .rst_n(rst_n), .dir(dir), .thr_cfg(thr_cfg),
      .exec_start(exec_start), .sector_end(sector_end), .term_count(term_count),
      .level_nxt(level_nxt), .req(req), .result_ok(result_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      err_flag <= 1'b0;
      else if (bad_op) err_flag <= 1'b1;
   end

   assign irq     = req && !dma_mode;
   assign dma_req = req && dma_mode;
   if (DUAL_OUT) begin : g_status_bit
      assign rqm = req && !dma_mode;
   end else begin : g_no_status_bit
      assign rqm = 1'b0;
   end
endmodule

// File: rtl/fifo_svc_req_chk.sv
module fifo_svc_req_chk #(
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             to_host,
   input logic             disk_wr,
   input logic             disk_rd,
   input logic             host_wr,
   input logic             host_rd,
   input logic [CNT_W-1:0] level,
   input logic             irq,
   input logic             dma_req,
   input logic             result_ok,
   input logic             err_flag
);
   logic push_c, pop_c, any_req;
   assign push_c  = to_host ? disk_wr : host_wr;
   assign pop_c   = to_host ? host_rd : disk_rd;
   assign any_req = irq || dma_req;

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH)); // R10
   AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && dma_req)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_c && !pop_c && level == CNT_W'(DEPTH)) |=> (level == CNT_W'(DEPTH))); // R9
   AST_UNDERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_c && level == '0) |=> err_flag); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R9
   AST_READ_REQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (to_host && $stable(to_host) && any_req) |-> (level != '0)); // R4
   AST_WRITE_REQ_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (!to_host && $stable(to_host) && any_req) |-> (level != CNT_W'(DEPTH))); // R6
   AST_RESULT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      result_ok |-> (level == '0 && !to_host)); // R7
endmodule

bind fifo_svc_req fifo_svc_req_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .to_host(to_host), .disk_wr(disk_wr),
   .disk_rd(disk_rd), .host_wr(host_wr), .host_rd(host_rd), .level(level),
   .irq(irq), .dma_req(dma_req), .result_ok(result_ok), .err_flag(err_flag)
);

// File: tb/fifo_svc_req_test.sv
module fifo_svc_req_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       to_host = 1'b1, dma_mode = 1'b0;
   logic [3:0] thr_cfg = 4'd0;
   logic       exec_start = 0, sector_end = 0, term_count = 0;
   logic       disk_wr = 0, disk_rd = 0, host_wr = 0, host_rd = 0;
   logic [7:0] disk_wdata = 0, host_wdata = 0;
   logic [7:0] rd_data;
   logic [4:0] level;
   logic       irq, rqm, dma_req, result_ok, err_flag;

   int checks = 0, errors = 0;
   bit finished = 0;
   string req_tag = "R2";

   // reference model state
   byte unsigned q[$];
   int  m_req = 0, m_act = 0, m_done = 0, m_res = 0, m_err = 0;

   always #5 clk = ~clk;

   fifo_svc_req uut (
      .clk(clk), .rst_n(rst_n), .to_host(to_host), .dma_mode(dma_mode),
      .thr_cfg(thr_cfg), .exec_start(exec_start), .sector_end(sector_end),
      .term_count(term_count), .disk_wr(disk_wr), .disk_wdata(disk_wdata),
      .disk_rd(disk_rd), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .rd_data(rd_data), .level(level), .irq(irq),
      .rqm(rqm), .dma_req(dma_req), .result_ok(result_ok), .err_flag(err_flag)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_req = 0; m_act = 0; m_done = 0; m_res = 0; m_err = 0;
      end else begin
         int sz, thr, n;
         bit psh, pp;
         byte unsigned pd;
         psh = to_host ? disk_wr : host_wr;
         pp  = to_host ? host_rd : disk_rd;
         pd  = to_host ? disk_wdata : host_wdata;
         sz  = q.size();
         thr = int'(thr_cfg) + 1;
         if ((psh && sz == 16) || (pp && sz == 0)) m_err = 1;
         if (pp && sz > 0) void'(q.pop_front());
         if (psh && sz < 16) q.push_back(pd);
         n = q.size();
         if (exec_start) m_act = 1;
         if (term_count) m_act = 0;
         if (term_count) m_done = 1;
         if (exec_start) m_done = 0;
         if (to_host) begin
            if (n == 0) m_req = 0;
            else if (n >= 16 - thr || sector_end) m_req = 1;
         end else begin
            if (m_act == 0) m_req = 0;
            else if (n == 16) m_req = 0;
            else if (exec_start) m_req = 1;
            else if (n == thr) m_req = 1;
         end
         m_res = (!to_host && m_done != 0 && n == 0) ? 1 : 0;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk({req_tag, " R8 irq"}, int'(irq), (m_req != 0 && !dma_mode) ? 1 : 0);
      chk({req_tag, " R8 rqm"}, int'(rqm), (m_req != 0 && !dma_mode) ? 1 : 0);
      chk({req_tag, " R8 dma_req"}, int'(dma_req), (m_req != 0 && dma_mode) ? 1 : 0);
      chk("R7 result_ok", int'(result_ok), m_res);
      chk("R9 err_flag", int'(err_flag), m_err);
      chk("R10 level", int'(level), q.size());
      if (q.size() > 0) chk("R10 rd_data", int'(rd_data), int'(q[0]));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      exec_start = 0; sector_end = 0; term_count = 0;
      disk_wr = 0; disk_rd = 0; host_wr = 0; host_rd = 0;
      compare_all();
   endtask

   task automatic do_reset(bit dir, bit dma, logic [3:0] cfg);
      @(negedge clk);
      rst_n = 0; to_host = dir; dma_mode = dma; thr_cfg = cfg;
      tick(); tick();
      rst_n = 1;
      // R11: reset state
      chk("R11 level", int'(level), 0);
      chk("R11 req", int'(irq | rqm | dma_req), 0);
      chk("R11 result_ok", int'(result_ok), 0);
      chk("R11 err_flag", int'(err_flag), 0);
   endtask

   task automatic disk_push(int cnt, bit last_is_sector_end);
      for (int i = 0; i < cnt; i++) begin
         disk_wr = 1; disk_wdata = 8'($urandom);
         sector_end = last_is_sector_end && (i == cnt - 1);
         tick();
      end
   endtask

   task automatic host_push(int cnt);
      for (int i = 0; i < cnt; i++) begin
         host_wr = 1; host_wdata = 8'($urandom);
         tick();
      end
   endtask

   task automatic host_pop(int cnt);
      for (int i = 0; i < cnt; i++) begin host_rd = 1; tick(); end
   endtask

   task automatic disk_pop(int cnt);
      for (int i = 0; i < cnt; i++) begin disk_rd = 1; tick(); end
   endtask

   initial begin
      // Read direction, interrupt style, threshold 4 -> mark 12 (R1, R2, R4)
      req_tag = "R1 R2 R4";
      do_reset(1'b1, 1'b0, 4'd3);
      disk_push(11, 1'b0);
      chk("R2 below mark", int'(irq), 0);
      disk_push(1, 1'b0);
      chk("R2 at mark", int'(irq), 1);
      disk_push(2, 1'b0);
      host_pop(13);
      chk("R4 held until empty", int'(rqm), 1);
      host_pop(1);
      chk("R4 dropped at empty", int'(irq), 0);
      host_pop(1);
      chk("R9 underflow flagged", int'(err_flag), 1);
      chk("R9 underflow level", int'(level), 0);
      // mode switch while request pending (R8)
      disk_push(12, 1'b0);
      dma_mode = 1; tick();
      chk("R8 dma route", int'(dma_req), 1);
      chk("R8 irq muted", int'(irq), 0);

      // Read direction, DMA, threshold 1 -> mark 15, sector end forces (R3)
      req_tag = "R3 R4";
      do_reset(1'b1, 1'b1, 4'd0);
      disk_push(4, 1'b0);
      chk("R3 no req before sector end", int'(dma_req), 0);
      disk_push(1, 1'b1);
      chk("R3 sector end forces req", int'(dma_req), 1);
      host_pop(5);
      chk("R4 drop after drain", int'(dma_req), 0);
      thr_cfg = 4'd15;
      disk_push(1, 1'b0);
      chk("R1 threshold 16 requests at one byte", int'(dma_req), 1);
      host_pop(1);

      // Write direction, interrupt style, threshold 4 (R5, R6, R7)
      req_tag = "R5 R6 R7";
      do_reset(1'b0, 1'b0, 4'd3);
      exec_start = 1; tick();
      chk("R5 exec raises req", int'(irq), 1);
      host_push(15);
      chk("R6 not yet full", int'(irq), 1);
      host_push(1);
      chk("R6 full drops req", int'(irq), 0);
      host_push(1);
      chk("R9 overflow flagged", int'(err_flag), 1);
      chk("R9 overflow level", int'(level), 16);
      disk_pop(11);
      chk("R6 above threshold", int'(irq), 0);
      disk_pop(1);
      chk("R6 reassert at threshold", int'(irq), 1);
      host_push(2);
      term_count = 1; tick();
      chk("R7 tc stops req", int'(irq), 0);
      chk("R7 not drained yet", int'(result_ok), 0);
      disk_pop(6);
      chk("R7 result after drain", int'(result_ok), 1);

      // Write direction, DMA, threshold 8
      req_tag = "R5 R6 R7";
      do_reset(1'b0, 1'b1, 4'd7);
      exec_start = 1; tick();
      chk("R5 dma exec", int'(dma_req), 1);
      host_push(16);
      disk_pop(7);
      chk("R6 dma above threshold", int'(dma_req), 0);
      disk_pop(1);
      chk("R6 dma at threshold", int'(dma_req), 1);
      host_push(8);
      chk("R6 dma full", int'(dma_req), 0);
      disk_pop(3);
      term_count = 1; tick();
      disk_pop(13);
      chk("R7 dma drained", int'(result_ok), 1);
      chk("R7 dma req off", int'(dma_req), 0);
      exec_start = 1; tick();
      chk("R5 new exec clears result", int'(result_ok), 0);

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule